// File: doc/BRIEF.md
# Smart Card Transmitter with Guard Time

This block is the transmit half of a character-oriented smart card UART. The host writes one byte at a time into a single-entry holding buffer. The byte moves into a frame register as soon as the serial side is free, and on that move it is translated for the selected coding convention. Each character goes out as a ten-bit frame on a line that idles high. Every bit lasts one elementary time unit (ETU). An external divider supplies a strobe that pulses ten times per ETU, and all serial timing is counted in these strobes.

The block enforces a programmable minimum distance between the start bits it sends. With the guard register at zero the distance is 12 ETU. A value N adds N whole ETU. The all-ones value instead selects a shorter distance that depends on the protocol: 11.8 ETU for the character protocol and 10.8 ETU for the block protocol. This is why timing is kept at tenth-of-ETU resolution.

The card can ask for the last character again. A repeated character keeps the serial side busy, goes ahead of any waiting buffered byte, and only has to respect the base 12 ETU distance.

Top module: `sc_tx_guard`

## Requirements
- R1: After reset `txd` is high and `buf_empty` is 0. While `tx_mode` is 0, `buf_empty` reads 0 and host writes are dropped. In the cycle after `tx_mode` goes to 1 (with no write in that cycle), `buf_empty` reads 1.
- R2: A write accepted while `buf_empty` is 1 makes `buf_empty` read 0 in the next cycle.
- R3: A write made while the buffer already holds a byte is ignored. The held byte is kept and the extra byte is never sent.
- R4: The held byte moves to the frame register only when the serial side is idle, meaning not waiting to start, not sending and not repeating. `buf_empty` reads 1 in the cycle after the move and stays 0 for as long as the serial side is busy.
- R5: A frame is one low start bit, eight data bits and one parity bit. Each bit lasts exactly 10 strobes. `txd` changes only at strobe edges and is high between frames.
- R6: With `conv_inv` = 0, the data bits are sent least significant bit first and are not inverted.
- R7: With `conv_inv` = 1, each data bit is inverted and the bits are sent most significant bit first.
- R8: The parity bit makes the number of ones over the eight sent data bits plus the parity bit even.
- R9: With `guard_ext` = 00h, back-to-back characters start exactly 120 strobes apart.
- R10: With `guard_ext` = N, for N from 01h to FEh, back-to-back characters start exactly 120 + 10·N strobes apart.
- R11: With `guard_ext` = FFh, back-to-back characters start 118 strobes apart when `proto_t1` = 0 and 108 strobes apart when `proto_t1` = 1. No start bit ever follows the previous one by fewer than 108 strobes.
- R12: A `retx_req` pulse after at least one frame has gone out (a pulse during a frame is held until that frame ends) resends the last frame unchanged. The resent frame starts 120 strobes after the previous start, whatever `guard_ext` holds. It takes priority over a buffered byte, which stays buffered. The next new byte then follows the resent frame at the normal guard distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode (buffer disabled) |
| conv_inv | input | 1 | Coding convention: 0 direct, 1 inverse |
| proto_t1 | input | 1 | Protocol select for the FFh spacing: 0 character, 1 block |
| guard_ext | input | 8 | Extra guard time in ETU; FFh selects the fractional spacing |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | 8 | Byte written by the host |
| retx_req | input | 1 | Card request to resend the last character |
| subtick | input | 1 | Strobe, ten pulses per ETU |
| buf_empty | output | 1 | Transmit buffer empty flag |
| txd | output | 1 | Serial line, idles high |

## Verification
The buffer-to-frame handover and a pending resend request can become due in the same cycle, when a frame ends with a byte waiting in the buffer and a resend already requested. The bench provokes this by writing a second byte while the first frame is on the line and then pulsing `retx_req` in the middle of that frame. It judges the outcome from the line alone: the repeated frame must come first at 120 strobes, the buffered byte must still be held when the repeat starts, and the byte must follow at its guard distance. Back-to-back writes under randomly chosen guard, protocol and convention settings check frame contents and exact start spacing against values computed in the bench.

// File: rtl/sc_tx_pkg.sv
// Shared constants and types for the smart card transmitter.
// Assumes a strobe that pulses SUBS times per ETU.
package sc_tx_pkg;
    localparam int DATA_W     = 8;
    localparam int GUARD_W    = 8;
    localparam int SUBS       = 10;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int BASE_ETU   = 12;
    localparam int FRAC_T0    = 118;
    localparam int FRAC_T1    = 108;
    localparam int CNT_W      = 12;
    localparam int SUB_W      = $clog2(SUBS);
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int BASE_GAP   = BASE_ETU * SUBS;

    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SEND} tx_state_t;
    typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/sc_tx_encode.sv
// Builds the serial frame for one byte: start bit, data in send order,
// then even parity. Bit 0 of the frame is sent first.
// Assumes the convention input is stable while the byte is captured.
module sc_tx_encode
    import sc_tx_pkg::*;
(
    input  logic              conv_inv,
    input  logic [DATA_W-1:0] data,
    output frame_t            frame
);
    logic [DATA_W-1:0] ordered;

    // Place each data bit at its send position for the chosen convention.
    for (genvar i = 0; i < DATA_W; i++) begin : g_order
        assign ordered[i] = conv_inv ? ~data[DATA_W-1-i] : data[i];
    end

    // Parity last, data in the middle, low start bit first.
    assign frame = {^ordered, ordered, 1'b0};
endmodule

// File: rtl/sc_tx_holdbuf.sv
// Single-entry host transmit buffer with its empty flag.
// Assumes the consumer asserts take only while valid is high.
module sc_tx_holdbuf
    import sc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              buf_empty
);
    logic valid_nxt;

    // Next occupancy: drained by the consumer, filled by an accepted write.
    always_comb begin
        valid_nxt = valid;
        if (!tx_mode)
            valid_nxt = 1'b0;
        else if (take)
            valid_nxt = 1'b0;
        else if (wr_en && !valid)
            valid_nxt = 1'b1;
    end

    // Occupancy and the host-visible empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            buf_empty <= 1'b0;
        end else begin
            valid     <= valid_nxt;
            buf_empty <= tx_mode && !valid_nxt;
        end
    end

    // Capture the byte only when the buffer is free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (tx_mode && wr_en && !valid)
            data <= wr_data;
    end

    AST_RX_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |=> !buf_empty); // R1
    AST_MODE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_mode) && !wr_en) |=> buf_empty); // R1
    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && wr_en && buf_empty) |=> !buf_empty); // R2
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && valid && !take) |=> (valid && $stable(data))); // R3
endmodule

// File: rtl/sc_tx_spacing.sv
// Counts strobes since the last start bit and says when the next one may go.
// The counter saturates, so the first start after a long idle is not delayed.
// Assumes launch is only raised in a strobe cycle.
module sc_tx_spacing
    import sc_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               subtick,
    input  logic               launch,
    input  logic               retx_arm,
    input  logic               proto_t1,
    input  logic [GUARD_W-1:0] guard_ext,
    output logic               gap_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] req;

    // Required distance in strobes for the frame waiting to start.
    always_comb begin
        if (retx_arm)
            req = CNT_W'(BASE_GAP);
        else if (guard_ext == {GUARD_W{1'b1}})
            req = proto_t1 ? CNT_W'(FRAC_T1) : CNT_W'(FRAC_T0);
        else
            req = CNT_W'(BASE_GAP) + CNT_W'(guard_ext) * CNT_W'(SUBS);
    end

    // Strobe counter, cleared by each start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_MAX;
        else if (launch)
            cnt_q <= '0;
        else if (subtick && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign gap_ok = cnt_q >= (req - 1'b1);

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (cnt_q >= CNT_W'(FRAC_T1 - 1))); // R11
    AST_LAUNCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> subtick); // R5
endmodule

// File: rtl/sc_tx_shifter.sv
// Serial side: waits for the spacing window, shifts a frame out bit by bit,
// keeps the last frame for a resend and gives a resend priority over the buffer.
// Assumes the strobe pulses SUBS times per ETU.
module sc_tx_shifter
    import sc_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   subtick,
    input  logic   buf_valid,
    input  frame_t enc_frame,
    input  logic   retx_req,
    input  logic   gap_ok,
    output logic   take,
    output logic   launch,
    output logic   retx_arm,
    output logic   txd
);
    tx_state_t          st;
    frame_t             frame_q;
    logic [SUB_W-1:0]   sub_q;
    logic [BIT_W-1:0]   bit_q;
    logic [BIT_W-1:0]   nxt_bit;
    logic               line_q;
    logic               sent_any;
    logic               retx_pend;
    logic               retx_q;
    logic               retx_go;

    assign retx_go  = (st == ST_IDLE) && retx_pend;
    assign take     = (st == ST_IDLE) && !retx_pend && buf_valid;
    assign launch   = (st == ST_ARMED) && subtick && gap_ok;
    assign nxt_bit  = bit_q + 1'b1;
    assign retx_arm = retx_q;
    assign txd      = line_q;

    // Hold a resend request until the serial side is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retx_pend <= 1'b0;
        else if (retx_go)
            retx_pend <= 1'b0;
        else if (retx_req && sent_any)
            retx_pend <= 1'b1;
    end

    // Frame sequencing: arm, start on the spacing window, shift bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            frame_q  <= '1;
            sub_q    <= '0;
            bit_q    <= '0;
            line_q   <= 1'b1;
            sent_any <= 1'b0;
            retx_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (retx_go) begin
                        retx_q <= 1'b1;
                        st     <= ST_ARMED;
                    end else if (take) begin
                        frame_q <= enc_frame;
                        retx_q  <= 1'b0;
                        st      <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (launch) begin
                        st       <= ST_SEND;
                        line_q   <= frame_q[0];
                        sub_q    <= '0;
                        bit_q    <= '0;
                        sent_any <= 1'b1;
                    end
                end
                ST_SEND: begin
                    if (subtick) begin
                        if (sub_q == SUB_W'(SUBS - 1)) begin
                            sub_q <= '0;
                            if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
                                st     <= ST_IDLE;
                                line_q <= 1'b1;
                            end else begin
                                bit_q  <= nxt_bit;
                                line_q <= frame_q[nxt_bit];
                            end
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SEND) |-> line_q); // R5
    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q < SUB_W'(SUBS)); // R5
    AST_FRAME_KEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(frame_q)); // R4
    AST_LINE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !subtick |=> $stable(line_q)); // R5
endmodule

// File: rtl/sc_tx_guard.sv
// Top of the smart card transmitter: host buffer, encoder, spacing timer
// and serial shifter. Assumes subtick comes from an external ETU divider.
module sc_tx_guard
    import sc_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_mode,
    input  logic               conv_inv,
    input  logic               proto_t1,
    input  logic [GUARD_W-1:0] guard_ext,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               retx_req,
    input  logic               subtick,
    output logic               buf_empty,
    output logic               txd
);
    logic              take;
    logic              buf_valid;
    logic [DATA_W-1:0] buf_data;
    frame_t            enc_frame;
    logic              launch;
    logic              retx_arm;
    logic              gap_ok;

    sc_tx_holdbuf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_mode   (tx_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .valid     (buf_valid),
        .data      (buf_data),
        .buf_empty (buf_empty)
    );

    sc_tx_encode u_enc (
        .conv_inv (conv_inv),
        .data     (buf_data),
        .frame    (enc_frame)
    );

    sc_tx_spacing u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .subtick   (subtick),
        .launch    (launch),
        .retx_arm  (retx_arm),
        .proto_t1  (proto_t1),
        .guard_ext (guard_ext),
        .gap_ok    (gap_ok)
    );

    sc_tx_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .subtick   (subtick),
        .buf_valid (buf_valid),
        .enc_frame (enc_frame),
        .retx_req  (retx_req),
        .gap_ok    (gap_ok),
        .take      (take),
        .launch    (launch),
        .retx_arm  (retx_arm),
        .txd       (txd)
    );
endmodule

// File: tb/sc_tx_guard_test.sv
module sc_tx_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_mode = 1'b0;
    logic       conv_inv = 1'b0;
    logic       proto_t1 = 1'b0;
    logic [7:0] guard_ext = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       retx_req = 1'b0;
    logic       subtick = 1'b0;
    logic       buf_empty;
    logic       txd;

    always #5 clk = ~clk;

    sc_tx_guard uut (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .conv_inv(conv_inv),
        .proto_t1(proto_t1), .guard_ext(guard_ext), .wr_en(wr_en),
        .wr_data(wr_data), .retx_req(retx_req), .subtick(subtick),
        .buf_empty(buf_empty), .txd(txd)
    );

    int checks = 0;
    int errors = 0;
    int strobe_cnt = 0;
    bit strobe_on = 1'b0;
    bit in_frame = 1'b0;
    int start_s = 0;
    int last_start = 0;
    int rel = 0;
    logic [9:0] shreg = '0;
    logic [9:0] exp_frame [0:255];
    int         exp_gap   [0:255];
    string      exp_gtag  [0:255];
    string      exp_ftag  [0:255];
    int exp_n = 0;
    int got_n = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [9:0] enc(input logic [7:0] d, input bit inv);
        logic [9:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[i+1] = inv ? ~d[7-i] : d[i];
        f[9] = ^f[8:1];
        return f;
    endfunction

    function automatic int gap_of(input logic [7:0] g, input bit t1);
        if (g == 8'hFF) return t1 ? 108 : 118;
        return 120 + 10 * int'(g);
    endfunction

    function automatic string gtag_of(input logic [7:0] g);
        if (g == 8'hFF) return "R11 spacing";
        if (g == 8'h00) return "R9 spacing";
        return "R10 spacing";
    endfunction

    task automatic push(input logic [9:0] f, input int gap, input string gt, input string ft);
        exp_frame[exp_n] = f;
        exp_gap[exp_n]   = gap;
        exp_gtag[exp_n]  = gt;
        exp_ftag[exp_n]  = ft;
        exp_n++;
    endtask

    // Line monitor and strobe driver: one process so the order is fixed.
    always @(negedge clk) begin
        if (subtick) begin
            strobe_cnt++;
            if (in_frame) begin
                rel = strobe_cnt - start_s;
                if (rel < 100 && rel % 10 == 5) shreg[rel/10] = txd;
                if (rel == 100) begin
                    in_frame = 1'b0;
                    check(txd == 1'b1, "R5 line high after frame", txd, 1);
                    if (got_n < exp_n) begin
                        check(shreg == exp_frame[got_n], exp_ftag[got_n], shreg, exp_frame[got_n]);
                        if (exp_gap[got_n] >= 0)
                            check(start_s - last_start == exp_gap[got_n], exp_gtag[got_n],
                                  start_s - last_start, exp_gap[got_n]);
                    end else begin
                        check(1'b0, "R3 unexpected frame", got_n + 1, exp_n);
                    end
                    got_n++;
                    last_start = start_s;
                end
            end else if (!txd) begin
                in_frame = 1'b1;
                start_s  = strobe_cnt;
            end
        end
        subtick <= strobe_on ? 1'($urandom % 2) : 1'b0;
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic wait_done();
        while (got_n < exp_n) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [7:0] g, input bit t1, input bit inv);
        @(negedge clk);
        guard_ext = g;
        proto_t1  = t1;
        conv_inv  = inv;
    endtask

    // Back-to-back characters under one setting; spacing checked after the first.
    task automatic batch(input int n, input logic [7:0] g, input bit t1, input bit inv);
        logic [7:0] d;
        set_cfg(g, t1, inv);
        for (int k = 0; k < n; k++) begin
            wait_empty();
            d = 8'($urandom);
            wr(d);
            push(enc(d, inv), (k == 0) ? -1 : gap_of(g, t1), gtag_of(g),
                 inv ? "R7 R8 inverse frame" : "R6 R8 direct frame");
        end
        wait_done();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7816));
        strobe_on = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 reset line", txd, 1);
        check(buf_empty == 1'b0, "R1 reset empty flag", buf_empty, 0);

        // Receive mode: write dropped, flag stays low.
        wr(8'h3C);
        check(buf_empty == 1'b0, "R1 write in receive mode", buf_empty, 0);
        repeat (40) @(negedge clk);
        tx_mode = 1'b1;
        @(negedge clk);
        check(buf_empty == 1'b1, "R1 transmit mode sets empty", buf_empty, 1);

        // Direct convention, guard zero, with full-buffer overwrite attempt.
        set_cfg(8'h00, 1'b0, 1'b0);
        wr(8'hA5);
        check(buf_empty == 1'b0, "R2 write clears empty", buf_empty, 0);
        push(enc(8'hA5, 1'b0), -1, "R9 spacing", "R6 R8 direct frame");
        @(negedge clk);
        check(buf_empty == 1'b1, "R4 empty after move", buf_empty, 1);
        wr(8'h01);
        push(enc(8'h01, 1'b0), 120, "R9 spacing", "R6 R8 direct frame");
        repeat (20) @(negedge clk);
        check(buf_empty == 1'b0, "R4 held while serial busy", buf_empty, 0);
        wr(8'hFE);
        wait_done();

        // Fractional spacings and a whole-ETU guard.
        batch(2, 8'hFF, 1'b0, 1'b1);
        batch(2, 8'hFF, 1'b1, 1'b0);
        batch(3, 8'h03, 1'b0, 1'b1);

        // Resend pending while a byte waits: resend first at base spacing.
        set_cfg(8'h05, 1'b0, 1'b0);
        wait_empty();
        wr(8'h5A);
        push(enc(8'h5A, 1'b0), -1, "R10 spacing", "R6 R8 direct frame");
        wait_empty();
        wr(8'hC3);
        while (txd) @(negedge clk);
        repeat (30) @(negedge clk);
        retx_req = 1'b1;
        @(negedge clk);
        retx_req = 1'b0;
        push(enc(8'h5A, 1'b0), 120, "R12 resend spacing", "R12 resend frame");
        push(enc(8'hC3, 1'b0), 170, "R12 byte after resend", "R6 R8 direct frame");
        while (got_n < 1) @(negedge clk);
        while (txd) @(negedge clk);
        check(buf_empty == 1'b0, "R12 buffered byte kept during resend", buf_empty, 0);
        wait_done();

        // Constrained random settings.
        for (int i = 0; i < 10; i++) begin
            logic [7:0] g;
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0)      g = 8'h00;
            else if (sel == 1) g = 8'hFF;
            else               g = 8'(1 + $urandom % 6);
            batch(2 + int'($urandom % 2), g, 1'($urandom % 2), 1'($urandom % 2));
        end

        check(got_n == exp_n, "R3 frame count", got_n, exp_n);
        summary();
        $finish;
    end
endmodule